// File: doc/BRIEF.md
# Eight-Level Vectored Interrupt Controller

This block gathers eight interrupt request lines into a single interrupt output to a processor. Software reaches it through a byte-wide port that has two addresses: a command address and a data address. After reset, software programs the block with a short initialization sequence. That sequence sets the vector base, the cascade configuration word and the end-of-interrupt policy. From then on, writes to the data address set which inputs are masked.

At run time the block latches rising edges on the request lines. It picks the most urgent request that is unmasked and not already blocked by a level in service. When the processor pulses the acknowledge input, the block answers with an 8-bit vector. Software then retires the serviced level with a specific end-of-interrupt command, or the auto-EOI mode skips that step. A read from the command address returns either the request register or the in-service register. Software selects which one, and the selection stays in force until it is changed.

Top module: `pic8_ctrl`

## Requirements
- R1: After reset the mask register reads 0xFF, the request and in-service registers are zero, command-address reads return the request register, and `int_out` is low.
- R2: A command-address write with bit 4 set starts initialization and clears the mask to 0x00 and the in-service register. In that first word, bit 1 set means single mode and bit 0 set means a mode word follows. The following data-address writes load, in this order, the vector base, the cascade word (skipped in single mode) and the mode word (skipped unless requested). Data-address writes after that load the mask.
- R3: The vector is the upper five bits of the programmed base joined with the 3-bit level number. Base bits 2:0 are ignored.
- R4: A request bit is set on a rising edge of its input. It is cleared when the input goes low or when an acknowledge moves that level into service.
- R5: Level 0 has the highest priority and level 7 the lowest. `int_out` is high only when the highest-priority unmasked pending level is numerically below every in-service level.
- R6: When `ack` is pulsed while `int_out` is high, the next cycle shows `vec_valid` high with the vector of the winning level. That level's request bit is cleared, and in normal mode its in-service bit is set.
- R7: A command byte 0x60+n (bits 7:3 = 01100) clears in-service bit n only.
- R8: A command byte 0x0A selects the request register and 0x0B selects the in-service register for command-address reads. The selection persists. Data-address reads return the mask.
- R9: With bit 1 of the mode word set (auto-EOI), an acknowledge sets no in-service bit.
- R10: An acknowledge while `int_out` is low returns the base with level 7. It changes no in-service bit, and this holds even when level 7 is masked.
- R11: `casc_cfg` holds the last cascade word. In single mode it is cleared to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 1 | 0 = command address, 1 = data address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current `addr` |
| irq_in | input | 8 | Request lines; bit n is level n |
| ack | input | 1 | One-cycle acknowledge pulse |
| int_out | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector, valid while `vec_valid` is high |
| vec_valid | output | 1 | High for the cycle after an acknowledge |
| casc_cfg | output | 8 | Programmed cascade word |

## Verification
The bench goes after priority nesting. A lower-priority request must stay blocked while a higher level is in service; a design that compared against any in-service bit, or ignored in-service state, would raise the interrupt at the wrong time. It checks that a specific EOI clears only its own level, which would break if the level field were decoded wrongly. It also drops a request before the acknowledge and acknowledges with everything masked. A design that forgot spurious handling would return a stale vector or set a phantom in-service bit. Finally it reinitializes the block in single mode, with no mode word, and with auto-EOI and a misaligned base. This exposes a sequencer that consumes the wrong word or keeps the low base bits.

// File: rtl/pic8_pkg.sv
package pic8_pkg;
    localparam int NUM_LVL = 8;
    localparam int LVL_W   = $clog2(NUM_LVL);
    localparam int DW      = 8;

    // command-byte field positions
    localparam int INIT_BIT  = 4;
    localparam int SEL_BIT   = 3;
    localparam int SNGL_BIT  = 1;
    localparam int MODE_BIT  = 0;
    localparam int AEOI_BIT  = 1;
    localparam logic [2:0] EOI_SPEC = 3'b011;

    typedef enum logic [1:0] {SEQ_RUN, SEQ_BASE, SEQ_CASC, SEQ_MODE} seq_e;

    typedef struct packed {
        logic [DW-1:LVL_W] base_hi;
        logic [DW-1:0]     casc;
        logic              aeoi;
        logic              rd_isr;
    } cfg_t;

    typedef struct packed {
        logic             hit;
        logic [LVL_W-1:0] lvl;
    } pick_t;

    // lowest set index wins
    function automatic pick_t first_set(input logic [NUM_LVL-1:0] v);
        pick_t p;
        p = '0;
        for (int i = NUM_LVL - 1; i >= 0; i--) begin
            if (v[i]) begin
                p.hit = 1'b1;
                p.lvl = LVL_W'(i);
            end
        end
        return p;
    endfunction
endpackage

// File: rtl/pic8_regif.sv
module pic8_regif
    import pic8_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic               addr,
    input  logic [DW-1:0]      wdata,
    output cfg_t               cfg,
    output logic [NUM_LVL-1:0] imr,
    output logic [NUM_LVL-1:0] eoi_clr,
    output logic               init_go
);
    seq_e st;
    logic need_casc;
    logic need_mode;
    logic cmd_wr;
    logic is_eoi;

    assign cmd_wr  = wr_en && !addr;
    assign init_go = cmd_wr && wdata[INIT_BIT];
    assign is_eoi  = cmd_wr && !wdata[INIT_BIT] && !wdata[SEL_BIT]
                     && (wdata[7:5] == EOI_SPEC);

    always_comb begin
        eoi_clr = '0;
        if (is_eoi)
            eoi_clr[wdata[LVL_W-1:0]] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= SEQ_RUN;
            need_casc <= 1'b0;
            need_mode <= 1'b0;
            cfg       <= '0;
            imr       <= '1;
        end else if (wr_en) begin
            if (init_go) begin
                st         <= SEQ_BASE;
                need_casc  <= !wdata[SNGL_BIT];
                need_mode  <= wdata[MODE_BIT];
                imr        <= '0;
                cfg.rd_isr <= 1'b0;
                if (!wdata[MODE_BIT])
                    cfg.aeoi <= 1'b0;
                if (wdata[SNGL_BIT])
                    cfg.casc <= '0;
            end else if (!addr) begin
                if (wdata[SEL_BIT] && wdata[1])
                    cfg.rd_isr <= wdata[0];
            end else begin
                case (st)
                    SEQ_BASE: begin
                        cfg.base_hi <= wdata[DW-1:LVL_W];
                        st <= need_casc ? SEQ_CASC : (need_mode ? SEQ_MODE : SEQ_RUN);
                    end
                    SEQ_CASC: begin
                        cfg.casc <= wdata;
                        st <= need_mode ? SEQ_MODE : SEQ_RUN;
                    end
                    SEQ_MODE: begin
                        cfg.aeoi <= wdata[AEOI_BIT];
                        st <= SEQ_RUN;
                    end
                    default: imr <= wdata;
                endcase
            end
        end
    end
endmodule

// File: rtl/pic8_prio.sv
module pic8_prio
    import pic8_pkg::*;
(
    input  logic [NUM_LVL-1:0] irr,
    input  logic [NUM_LVL-1:0] imr,
    input  logic [NUM_LVL-1:0] isr,
    output pick_t              grant
);
    pick_t req_p;
    pick_t svc_p;

    always_comb begin
        req_p     = first_set(irr & ~imr);
        svc_p     = first_set(isr);
        grant.lvl = req_p.lvl;
        grant.hit = req_p.hit && (!svc_p.hit || (req_p.lvl < svc_p.lvl));
    end
endmodule

// File: rtl/pic8_svc.sv
module pic8_svc
    import pic8_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_LVL-1:0] irq_in,
    input  logic               ack,
    input  pick_t              grant,
    input  cfg_t               cfg,
    input  logic [NUM_LVL-1:0] eoi_clr,
    input  logic               init_go,
    output logic [NUM_LVL-1:0] irr,
    output logic [NUM_LVL-1:0] isr,
    output logic [DW-1:0]      vec_out,
    output logic               vec_valid
);
    logic [NUM_LVL-1:0] irq_q;
    logic [NUM_LVL-1:0] win_oh;
    logic [NUM_LVL-1:0] take;
    logic [NUM_LVL-1:0] rise;

    assign rise = irq_in & ~irq_q;

    always_comb begin
        win_oh = '0;
        win_oh[grant.lvl] = 1'b1;
        take = (ack && grant.hit) ? win_oh : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q     <= '0;
            irr       <= '0;
            isr       <= '0;
            vec_out   <= '0;
            vec_valid <= 1'b0;
        end else begin
            irq_q     <= irq_in;
            irr       <= (irr | rise) & irq_in & ~take;
            vec_valid <= ack;
            if (ack)
                vec_out <= {cfg.base_hi, grant.hit ? grant.lvl : {LVL_W{1'b1}}};
            if (init_go)
                isr <= '0;
            else
                isr <= (isr & ~eoi_clr) | (cfg.aeoi ? '0 : take);
        end
    end
endmodule

// File: rtl/pic8_ctrl.sv
module pic8_ctrl
    import pic8_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic        addr,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    input  logic [7:0]  irq_in,
    input  logic        ack,
    output logic        int_out,
    output logic [7:0]  vec_out,
    output logic        vec_valid,
    output logic [7:0]  casc_cfg
);
    cfg_t               cfg_r;
    logic [NUM_LVL-1:0] imr_r;
    logic [NUM_LVL-1:0] irr_r;
    logic [NUM_LVL-1:0] isr_r;
    logic [NUM_LVL-1:0] eoi_clr;
    logic               init_go;
    pick_t              grant;

    pic8_regif u_regif (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .cfg(cfg_r), .imr(imr_r), .eoi_clr(eoi_clr), .init_go(init_go)
    );

    pic8_prio u_prio (
        .irr(irr_r), .imr(imr_r), .isr(isr_r), .grant(grant)
    );

    pic8_svc u_svc (
        .clk(clk), .rst(rst), .irq_in(irq_in), .ack(ack), .grant(grant),
        .cfg(cfg_r), .eoi_clr(eoi_clr), .init_go(init_go),
        .irr(irr_r), .isr(isr_r), .vec_out(vec_out), .vec_valid(vec_valid)
    );

    assign int_out  = grant.hit;
    assign casc_cfg = cfg_r.casc;
    assign rdata    = addr ? imr_r : (cfg_r.rd_isr ? isr_r : irr_r);
endmodule

// File: rtl/pic8_chk.sv
module pic8_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic       addr,
    input logic [7:0] wdata,
    input logic       ack,
    input logic       int_out,
    input logic [7:0] vec_out,
    input logic       vec_valid,
    input logic [7:0] irr,
    input logic [7:0] isr,
    input logic [7:0] imr,
    input logic       aeoi
);
    p_rst_state_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (imr == 8'hFF && isr == 8'h00 && irr == 8'h00));

    p_int_needs_req_r5: assert property (@(posedge clk) disable iff (rst)
        int_out |-> ((irr & ~imr) != 8'h00));

    p_ack_valid_r6: assert property (@(posedge clk) disable iff (rst)
        ack |=> vec_valid);

    p_no_ack_idle_r6: assert property (@(posedge clk) disable iff (rst)
        !ack |=> !vec_valid);

    p_ack_sets_one_r6: assert property (@(posedge clk) disable iff (rst)
        (ack && int_out && !aeoi && !wr_en)
            |=> ($countones(isr) == $countones($past(isr)) + 1));

    p_eoi_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !addr && wdata[7:3] == 5'b01100 && !ack)
            |=> !isr[$past(wdata[2:0])]);

    p_aeoi_keep_r9: assert property (@(posedge clk) disable iff (rst)
        (ack && aeoi && !wr_en) |=> $stable(isr));

    p_spurious_r10: assert property (@(posedge clk) disable iff (rst)
        (ack && !int_out && !wr_en) |=> (vec_out[2:0] == 3'b111 && $stable(isr)));
endmodule

bind pic8_ctrl pic8_chk u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .ack(ack), .int_out(int_out), .vec_out(vec_out), .vec_valid(vec_valid),
    .irr(irr_r), .isr(isr_r), .imr(imr_r), .aeoi(cfg_r.aeoi)
);

// File: tb/sim_pic8_ctrl.sv
module sim_pic8_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       addr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [7:0] irq_in = 8'h00;
    logic       ack = 1'b0;
    logic       int_out;
    logic [7:0] vec_out;
    logic       vec_valid;
    logic [7:0] casc_cfg;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    pic8_ctrl u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq_in(irq_in), .ack(ack), .int_out(int_out),
        .vec_out(vec_out), .vec_valid(vec_valid), .casc_cfg(casc_cfg)
    );

    typedef struct packed {
        logic [7:0] msk;
        logic [7:0] pat;
        logic [7:0] vec;
        logic       ex_int;
    } row_t;

    // base 0x20, all cases start with nothing in service
    localparam row_t ROWS [5] = '{
        '{8'h00, 8'h01, 8'h20, 1'b1},
        '{8'h00, 8'h0C, 8'h22, 1'b1},
        '{8'h04, 8'h0C, 8'h23, 1'b1},
        '{8'h00, 8'h80, 8'h27, 1'b1},
        '{8'hFF, 8'h10, 8'h27, 1'b0}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic pulse_ack;
        @(negedge clk);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic drive_irq(input logic [7:0] v);
        @(negedge clk);
        irq_in = v;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(1'b1, d); chk("R1 mask", d, 8'hFF);
        rd(1'b0, d); chk("R1 irr", d, 8'h00);
        chk("R1 int", {7'd0, int_out}, 8'h00);

        // R2 full init, cascade master on input 2
        wr(1'b0, 8'h11); wr(1'b1, 8'h20); wr(1'b1, 8'h04); wr(1'b1, 8'h01);
        chk("R11 casc", casc_cfg, 8'h04);
        rd(1'b1, d); chk("R2 mask cleared", d, 8'h00);
        wr(1'b1, 8'hFF);
        rd(1'b1, d); chk("R8 mask read", d, 8'hFF);

        // table walk: R5 R6 R7 R10
        foreach (ROWS[i]) begin
            wr(1'b1, ROWS[i].msk);
            drive_irq(ROWS[i].pat);
            chk($sformatf("R5 int row%0d", i), {7'd0, int_out}, {7'd0, ROWS[i].ex_int});
            pulse_ack();
            chk($sformatf("R6 valid row%0d", i), {7'd0, vec_valid}, 8'h01);
            chk($sformatf("R6 vec row%0d", i), vec_out, ROWS[i].vec);
            if (ROWS[i].ex_int)
                wr(1'b0, {5'b01100, ROWS[i].vec[2:0]});
            drive_irq(8'h00);
        end

        // R8 read select and R4/R6 request clearing
        wr(1'b1, 8'h00);
        wr(1'b0, 8'h0A);
        drive_irq(8'h20);
        rd(1'b0, d); chk("R4 irr set", d, 8'h20);
        pulse_ack();
        chk("R6 vec5", vec_out, 8'h25);
        rd(1'b0, d); chk("R6 irr cleared", d, 8'h00);
        wr(1'b0, 8'h0B);
        rd(1'b0, d); chk("R8 isr read", d, 8'h20);
        rd(1'b0, d); chk("R8 select persists", d, 8'h20);

        // R5 nesting
        drive_irq(8'h60);
        chk("R5 lower blocked", {7'd0, int_out}, 8'h00);
        drive_irq(8'h68);
        chk("R5 higher passes", {7'd0, int_out}, 8'h01);
        pulse_ack();
        chk("R6 vec3", vec_out, 8'h23);
        rd(1'b0, d); chk("R6 nested isr", d, 8'h28);
        wr(1'b0, 8'h65);
        rd(1'b0, d); chk("R7 only level5", d, 8'h08);
        chk("R5 blocked by 3", {7'd0, int_out}, 8'h00);
        wr(1'b0, 8'h63);
        chk("R5 unblocked", {7'd0, int_out}, 8'h01);
        pulse_ack();
        chk("R6 vec6", vec_out, 8'h26);
        wr(1'b0, 8'h66);
        drive_irq(8'h00);

        // R4 request dropped before acknowledge, R10 spurious
        wr(1'b0, 8'h0A);
        drive_irq(8'h02);
        drive_irq(8'h00);
        rd(1'b0, d); chk("R4 irr dropped", d, 8'h00);
        chk("R4 int low", {7'd0, int_out}, 8'h00);
        pulse_ack();
        chk("R10 spurious vec", vec_out, 8'h27);
        wr(1'b0, 8'h0B);
        rd(1'b0, d); chk("R10 isr untouched", d, 8'h00);

        // R10 with level 7 masked
        wr(1'b1, 8'hFF);
        pulse_ack();
        chk("R10 masked7 vec", vec_out, 8'h27);
        rd(1'b0, d); chk("R10 masked7 isr", d, 8'h00);

        // R2/R3/R9/R11 single mode, misaligned base, auto-EOI
        wr(1'b0, 8'h13); wr(1'b1, 8'h2D); wr(1'b1, 8'h03);
        chk("R11 single clears casc", casc_cfg, 8'h00);
        rd(1'b1, d); chk("R2 single mask", d, 8'h00);
        drive_irq(8'h04);
        pulse_ack();
        chk("R3 base low bits ignored", vec_out, 8'h2A);
        rd(1'b0, d); chk("R9 aeoi isr empty", d, 8'h00);
        drive_irq(8'h00);

        // R2 no mode word: next data write is the mask
        wr(1'b0, 8'h10); wr(1'b1, 8'h30); wr(1'b1, 8'h02);
        chk("R11 casc word", casc_cfg, 8'h02);
        wr(1'b1, 8'h5A);
        rd(1'b1, d); chk("R2 mask after short init", d, 8'h5A);
        wr(1'b1, 8'h00);
        wr(1'b0, 8'h0B);
        drive_irq(8'h01);
        pulse_ack();
        chk("R3 vec new base", vec_out, 8'h30);
        rd(1'b0, d); chk("R9 aeoi cleared by init", d, 8'h01);
        drive_irq(8'h00);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule